// File: doc/BRIEF.md
# Multi-Channel Bus Transaction Arbiter

This block lets several independent channel engines share one bus initiator port. Each channel posts a request: an operation (read, write or compare-and-swap), a base address, a burst length and, flit by flit, its write data. The arbiter puts one burst at a time onto the bus. It labels every command flit with the number of the channel it came from, carried in the transaction ID. While one channel waits for its answer, the bus stays free for the other channels, so their transactions interleave.

Responses can come back in any order across channels. The arbiter reads the returned ID and sends each response flit, together with its error bit, to the channel that owns it. It keeps one outstanding bit per channel. That bit is set when the last command flit of a burst is accepted and cleared when the last response flit for that channel arrives. A channel is never granted again while its bit is set, so each channel has at most one transaction in flight.

Top module: `chan_bus_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_valid`, every bit of `ch_flit_ack` and every bit of `ch_rsp_valid` are 0.
- R2: `cmd_id` holds the index of the granted channel, zero-extended to the ID width, on every flit of that channel's burst.
- R3: A granted burst is never split. Its flit k (counting from 0) carries address base + k*(DATA_W/8). `cmd_eop` is 1 exactly on flit number len, where len is the channel's length field and the burst has len+1 flits. While `cmd_ready` is 0, the command fields stay stable.
- R4: Selection is round-robin over the eligible channels, searching upward in cyclic order from the channel after the last one granted. After reset the last-granted index is NUM_CH-1, so channel 0 has top priority first.
- R5: A channel whose last command flit has been accepted is not granted again until the last flit of its response has arrived.
- R6: A response with `rsp_valid`=1 whose `rsp_id` names a channel with an outstanding transaction appears in the next cycle on `ch_rsp_valid` as that channel's bit alone, with `rsp_data` and `rsp_last` copied.
- R7: A response whose ID is NUM_CH or above, or names a channel with no outstanding transaction, raises no bit of `ch_rsp_valid`.
- R8: `rsp_err` is passed through to `ch_rsp_err`. An error response with `rsp_last`=1 still clears the channel's outstanding bit.
- R9: When the arbiter is idle and a channel is eligible (`ch_req_valid`=1 and nothing outstanding), `cmd_valid` rises one cycle later. After a burst's last flit is accepted, `cmd_valid` is 0 for one cycle.
- R10: Each accepted command flit (`cmd_valid` and `cmd_ready` both 1) pulses only the granted channel's bit of `ch_flit_ack`. `cmd_op` and `cmd_wdata` come from the granted channel. Operation codes: 0 read, 1 write, 2 compare-and-swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req_valid | input | NUM_CH | Per-channel request pending |
| ch_req_op | input | 2*NUM_CH | Per-channel operation code |
| ch_req_addr | input | ADDR_W*NUM_CH | Per-channel burst base address |
| ch_req_len | input | LEN_W*NUM_CH | Per-channel flit count minus one |
| ch_req_wdata | input | DATA_W*NUM_CH | Per-channel current write flit |
| ch_flit_ack | output | NUM_CH | Command flit accepted for channel |
| ch_rsp_valid | output | NUM_CH | Response flit delivered to channel |
| ch_rsp_data | output | DATA_W | Delivered response data |
| ch_rsp_err | output | 1 | Delivered error flag |
| ch_rsp_last | output | 1 | Delivered flit is the last of its response |
| cmd_valid | output | 1 | Bus command flit valid |
| cmd_ready | input | 1 | Bus accepts command flit |
| cmd_op | output | 2 | Bus operation code |
| cmd_addr | output | ADDR_W | Bus flit address |
| cmd_wdata | output | DATA_W | Bus write data |
| cmd_len | output | LEN_W | Bus burst length minus one |
| cmd_eop | output | 1 | Last flit of the command burst |
| cmd_id | output | ID_W | Transaction ID carrying the channel index |
| rsp_valid | input | 1 | Bus response flit valid |
| rsp_id | input | ID_W | Returned transaction ID |
| rsp_data | input | DATA_W | Returned data |
| rsp_err | input | 1 | Returned error flag |
| rsp_last | input | 1 | Last flit of the returned response |

## Verification
The assertions assume the channels follow their side of the protocol. A channel keeps its request fields steady from the moment it raises `ch_req_valid` until its final `ch_flit_ack`. It then drops the request and leaves it low until it has received its own last response flit. The assertions also assume the bus answers a channel only after that channel's burst is complete. The bench's channel models raise a new request only when they hold neither an active request nor a pending response. Its bus model keeps a response job per channel, created when the final command flit is accepted. Stray responses are sent only with IDs that are out of range or that name a channel with nothing outstanding.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CAS   = 2'd2
  } bus_op_e;
endpackage

// File: rtl/arb_rr_pick.sv
`timescale 1ns/1ps
// Round-robin selector: first eligible index after `last`, cyclically.
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_rsp_route.sv
`timescale 1ns/1ps
// Steers returned response flits to the owning channel by ID.
module arb_rsp_route #(
  parameter int N      = 4,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  input  logic              rsp_last,
  input  logic [N-1:0]      pending,
  output logic [N-1:0]      done,
  output logic [N-1:0]      out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic              out_last
);
  logic [N-1:0] hit;

  for (genvar c = 0; c < N; c++) begin : g_hit
    assign hit[c] = rsp_valid && (rsp_id == ID_W'(c)) && pending[c];
  end

  assign done = hit & {N{rsp_last}};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
      out_err   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= hit;
      if (|hit) begin
        out_data <= rsp_data;
        out_err  <= rsp_err;
        out_last <= rsp_last;
      end
    end
  end
endmodule

// File: rtl/chan_bus_arb.sv
`timescale 1ns/1ps
module chan_bus_arb #(
  parameter int NUM_CH = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        ch_req_valid,
  input  logic [2*NUM_CH-1:0]      ch_req_op,
  input  logic [ADDR_W*NUM_CH-1:0] ch_req_addr,
  input  logic [LEN_W*NUM_CH-1:0]  ch_req_len,
  input  logic [DATA_W*NUM_CH-1:0] ch_req_wdata,
  output logic [NUM_CH-1:0]        ch_flit_ack,
  output logic [NUM_CH-1:0]        ch_rsp_valid,
  output logic [DATA_W-1:0]        ch_rsp_data,
  output logic                     ch_rsp_err,
  output logic                     ch_rsp_last,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic [1:0]               cmd_op,
  output logic [ADDR_W-1:0]        cmd_addr,
  output logic [DATA_W-1:0]        cmd_wdata,
  output logic [LEN_W-1:0]         cmd_len,
  output logic                     cmd_eop,
  output logic [ID_W-1:0]          cmd_id,
  input  logic                     rsp_valid,
  input  logic [ID_W-1:0]          rsp_id,
  input  logic [DATA_W-1:0]        rsp_data,
  input  logic                     rsp_err,
  input  logic                     rsp_last
);
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BYTE_STEP = DATA_W / 8;

  logic              issuing_q;
  logic [CH_W-1:0]   gnt_q;
  logic [CH_W-1:0]   last_q;
  logic [LEN_W-1:0]  flit_q;
  logic [NUM_CH-1:0] outstanding_q;

  logic [NUM_CH-1:0] elig;
  logic              pick_found;
  logic [CH_W-1:0]   pick_idx;
  logic [NUM_CH-1:0] rsp_done;
  logic [NUM_CH-1:0] gnt_onehot;
  logic [NUM_CH-1:0] set_vec;
  logic [ADDR_W-1:0] sel_addr;
  logic              fire;

  assign elig = ch_req_valid & ~outstanding_q;

  arb_rr_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
    .elig  (elig),
    .last  (last_q),
    .found (pick_found),
    .pick  (pick_idx)
  );

  arb_rsp_route #(.N(NUM_CH), .ID_W(ID_W), .DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .rsp_last  (rsp_last),
    .pending   (outstanding_q),
    .done      (rsp_done),
    .out_valid (ch_rsp_valid),
    .out_data  (ch_rsp_data),
    .out_err   (ch_rsp_err),
    .out_last  (ch_rsp_last)
  );

  // Command side: fields muxed from the registered grant.
  assign sel_addr   = ch_req_addr[int'(gnt_q)*ADDR_W +: ADDR_W];
  assign cmd_valid  = issuing_q;
  assign cmd_op     = ch_req_op[int'(gnt_q)*2 +: 2];
  assign cmd_len    = ch_req_len[int'(gnt_q)*LEN_W +: LEN_W];
  assign cmd_wdata  = ch_req_wdata[int'(gnt_q)*DATA_W +: DATA_W];
  assign cmd_addr   = sel_addr + ADDR_W'(flit_q) * ADDR_W'(BYTE_STEP);
  assign cmd_eop    = (flit_q == cmd_len);
  assign cmd_id     = ID_W'(gnt_q);
  assign fire       = issuing_q && cmd_ready;
  assign gnt_onehot = NUM_CH'(1) << gnt_q;
  assign ch_flit_ack = fire ? gnt_onehot : '0;
  assign set_vec    = (fire && cmd_eop) ? gnt_onehot : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing_q     <= 1'b0;
      gnt_q         <= '0;
      last_q        <= CH_W'(NUM_CH - 1);
      flit_q        <= '0;
      outstanding_q <= '0;
    end else begin
      outstanding_q <= (outstanding_q & ~rsp_done) | set_vec;
      if (issuing_q) begin
        if (fire) begin
          if (cmd_eop) issuing_q <= 1'b0;
          else         flit_q    <= flit_q + LEN_W'(1);
        end
      end else if (pick_found) begin
        issuing_q <= 1'b1;
        gnt_q     <= pick_idx;
        last_q    <= pick_idx;
        flit_q    <= '0;
      end
    end
  end
endmodule

// File: rtl/chan_bus_arb_chk.sv
`timescale 1ns/1ps
module chan_bus_arb_chk #(
  parameter int NUM_CH = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_eop,
  input logic [ID_W-1:0]   cmd_id,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [NUM_CH-1:0] ch_flit_ack,
  input logic [NUM_CH-1:0] ch_rsp_valid,
  input logic              rsp_valid,
  input logic [ID_W-1:0]   rsp_id,
  input logic              rsp_last,
  input logic [NUM_CH-1:0] outstanding_q
);
  assert_id_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (int'(cmd_id) < NUM_CH));

  assert_burst_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_id) && $stable(cmd_addr)));

  assert_no_regrant_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !(|(outstanding_q & (NUM_CH'(1) << cmd_id))));

  assert_rsp_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_rsp_valid));

  assert_stray_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && int'(rsp_id) >= NUM_CH) |=> (ch_rsp_valid == '0));

  assert_last_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_last && int'(rsp_id) < NUM_CH &&
     (|(outstanding_q & (NUM_CH'(1) << rsp_id))))
    |=> !(|(outstanding_q & (NUM_CH'(1) << $past(rsp_id)))));

  assert_gap_after_burst_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_eop) |=> !cmd_valid);

  assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_flit_ack));
endmodule

bind chan_bus_arb chan_bus_arb_chk #(.NUM_CH(NUM_CH), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_eop       (cmd_eop),
  .cmd_id        (cmd_id),
  .cmd_addr      (cmd_addr),
  .ch_flit_ack   (ch_flit_ack),
  .ch_rsp_valid  (ch_rsp_valid),
  .rsp_valid     (rsp_valid),
  .rsp_id        (rsp_id),
  .rsp_last      (rsp_last),
  .outstanding_q (outstanding_q)
);

// File: tb/chan_bus_arb_tb.sv
`timescale 1ns/1ps
module chan_bus_arb_tb;
  localparam int N  = 4;
  localparam int IW = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    ch_req_valid = '0;
  logic [2*N-1:0]  ch_req_op    = '0;
  logic [AW*N-1:0] ch_req_addr  = '0;
  logic [LW*N-1:0] ch_req_len   = '0;
  logic [DW*N-1:0] ch_req_wdata = '0;
  logic [N-1:0]    ch_flit_ack;
  logic [N-1:0]    ch_rsp_valid;
  logic [DW-1:0]   ch_rsp_data;
  logic            ch_rsp_err, ch_rsp_last;
  logic            cmd_valid;
  logic            cmd_ready = 1'b0;
  logic [1:0]      cmd_op;
  logic [AW-1:0]   cmd_addr;
  logic [DW-1:0]   cmd_wdata;
  logic [LW-1:0]   cmd_len;
  logic            cmd_eop;
  logic [IW-1:0]   cmd_id;
  logic            rsp_valid = 1'b0;
  logic [IW-1:0]   rsp_id    = '0;
  logic [DW-1:0]   rsp_data  = '0;
  logic            rsp_err   = 1'b0;
  logic            rsp_last  = 1'b0;

  always #10 clk = ~clk;

  chan_bus_arb #(.NUM_CH(N), .ID_W(IW), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst(rst),
    .ch_req_valid(ch_req_valid), .ch_req_op(ch_req_op), .ch_req_addr(ch_req_addr),
    .ch_req_len(ch_req_len), .ch_req_wdata(ch_req_wdata), .ch_flit_ack(ch_flit_ack),
    .ch_rsp_valid(ch_rsp_valid), .ch_rsp_data(ch_rsp_data), .ch_rsp_err(ch_rsp_err),
    .ch_rsp_last(ch_rsp_last), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .cmd_eop(cmd_eop), .cmd_id(cmd_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Channel-side stimulus state
  int       b_req[N], b_op[N], b_len[N], b_cnt[N], b_wait[N], job_rem[N];
  bit [31:0] b_addr[N];
  // Reference model state
  int m_busy, m_g, m_f, m_last, m_rv, m_rch, m_rerr, m_rlast;
  int m_out[N];
  bit [31:0] m_rdata;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] wd(input int c, input int f);
    return 32'hC0DE0000 | (c << 8) | f;
  endfunction

  task automatic push_inputs();
    for (int c = 0; c < N; c++) begin
      ch_req_valid[c]           = b_req[c][0];
      ch_req_op[c*2 +: 2]       = 2'(b_op[c]);
      ch_req_addr[c*AW +: AW]   = b_addr[c];
      ch_req_len[c*LW +: LW]    = LW'(b_len[c]);
      ch_req_wdata[c*DW +: DW]  = wd(c, b_cnt[c]);
    end
  endtask

  task automatic step(input int cyc);
    int pct, pick, clr, fire, found, sid;
    bit [N-1:0] exp_ack;
    // 1: compare registered state
    chk(int'(cmd_valid) == m_busy, "R9 cmd_valid", cmd_valid, m_busy);
    if (m_busy != 0) begin
      chk(int'(cmd_id) == m_g, "R2 R4 cmd_id", cmd_id, m_g);
      chk(cmd_addr == b_addr[m_g] + 32'(m_f * 4), "R3 cmd_addr", cmd_addr, b_addr[m_g] + 32'(m_f * 4));
      chk(int'(cmd_eop) == int'(m_f == b_len[m_g]), "R3 cmd_eop", cmd_eop, m_f == b_len[m_g]);
      chk(int'(cmd_len) == b_len[m_g], "R3 cmd_len", cmd_len, b_len[m_g]);
      chk(int'(cmd_op) == b_op[m_g], "R10 cmd_op", cmd_op, b_op[m_g]);
      chk(cmd_wdata == wd(m_g, m_f), "R10 cmd_wdata", cmd_wdata, wd(m_g, m_f));
    end
    if (cmd_valid && int'(cmd_id) < N)
      chk(m_out[cmd_id] == 0, "R5 regrant while outstanding", cmd_id, 0);
    for (int c = 0; c < N; c++) begin
      chk(int'(ch_rsp_valid[c]) == int'(m_rv != 0 && m_rch == c), "R6 R7 ch_rsp_valid",
          ch_rsp_valid, (m_rv != 0) ? (1 << m_rch) : 0);
    end
    if (m_rv != 0) begin
      chk(ch_rsp_data == m_rdata, "R6 ch_rsp_data", ch_rsp_data, m_rdata);
      chk(int'(ch_rsp_last) == m_rlast, "R6 ch_rsp_last", ch_rsp_last, m_rlast);
      chk(int'(ch_rsp_err) == m_rerr, "R8 ch_rsp_err", ch_rsp_err, m_rerr);
    end
    for (int c = 0; c < N; c++)
      if (ch_rsp_valid[c] && ch_rsp_last) b_wait[c] = 0;

    // 2: new stimulus
    pct = (cyc < 300) ? 100 : ((cyc < 2000) ? 30 : 8);
    for (int c = 0; c < N; c++) begin
      if (b_req[c] == 0 && b_wait[c] == 0 && int'($urandom % 100) < pct) begin
        b_req[c]  = 1;
        b_op[c]   = int'($urandom % 3);
        b_len[c]  = (b_op[c] == 2) ? 1 : int'($urandom % 4);
        b_addr[c] = $urandom & 32'hFFFF_FFFC;
        b_cnt[c]  = 0;
      end
    end
    cmd_ready = (cyc < 40) ? (cyc >= 20) : (($urandom % 4) != 0);
    rsp_valid = 1'b0; rsp_last = 1'b0; rsp_err = 1'b0; rsp_id = '0; rsp_data = '0;
    pick = -1;
    if (($urandom % 3) != 0) begin
      sid = int'($urandom % N);
      for (int k = 0; k < N; k++)
        if (pick < 0 && job_rem[(sid + k) % N] > 0) pick = (sid + k) % N;
    end
    if (pick >= 0) begin
      rsp_valid = 1'b1; rsp_id = IW'(pick); rsp_data = $urandom;
      rsp_err = (($urandom % 8) == 0); rsp_last = (job_rem[pick] == 1);
    end else if (($urandom % 4) == 0) begin
      sid = int'($urandom % 16);
      if (sid >= N || m_out[sid] == 0) begin
        rsp_valid = 1'b1; rsp_id = IW'(sid); rsp_data = $urandom;
        rsp_err = $urandom % 2; rsp_last = $urandom % 2;
      end
    end
    push_inputs();
    #1;
    // 3: acknowledge pulse
    fire = (m_busy != 0 && cmd_ready) ? 1 : 0;
    exp_ack = (fire != 0) ? N'(1 << m_g) : '0;
    chk(ch_flit_ack == exp_ack, "R10 ch_flit_ack", ch_flit_ack, exp_ack);

    // 4: model next state
    clr = -1;
    if (rsp_valid && int'(rsp_id) < N && m_out[rsp_id] != 0) begin
      m_rv = 1; m_rch = int'(rsp_id); m_rdata = rsp_data;
      m_rerr = int'(rsp_err); m_rlast = int'(rsp_last);
      if (rsp_last) clr = int'(rsp_id);
    end else m_rv = 0;
    if (pick >= 0) job_rem[pick]--;
    if (m_busy != 0) begin
      if (fire != 0) begin
        b_cnt[m_g]++;
        if (m_f == b_len[m_g]) begin
          m_busy = 0; b_req[m_g] = 0; b_wait[m_g] = 1;
          job_rem[m_g] = (b_op[m_g] == 0) ? b_len[m_g] + 1 : 1;
          m_out[m_g] = 1;
        end else m_f++;
      end
    end else begin
      found = 0;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (m_last + k) % N;
        if (found == 0 && b_req[c] != 0 && m_out[c] == 0) begin
          found = 1; m_busy = 1; m_g = c; m_f = 0; m_last = c;
        end
      end
    end
    if (clr >= 0) m_out[clr] = 0;
    push_inputs();
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      b_req[c] = 0; b_op[c] = 0; b_len[c] = 0; b_cnt[c] = 0;
      b_wait[c] = 0; job_rem[c] = 0; b_addr[c] = '0; m_out[c] = 0;
    end
    m_busy = 0; m_g = 0; m_f = 0; m_last = N - 1;
    m_rv = 0; m_rch = 0; m_rerr = 0; m_rlast = 0; m_rdata = '0;
    push_inputs();
    repeat (4) begin
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", cmd_valid, 0);
      chk(ch_rsp_valid == '0, "R1 ch_rsp_valid in reset", ch_rsp_valid, 0);
      chk(ch_flit_ack == '0, "R1 ch_flit_ack in reset", ch_flit_ack, 0);
    end
    rst = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      step(cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule